// File: doc/BRIEF.md
# Address-Line Mirror Tester

This engine checks the address lines of a word-organised memory for stuck or shorted bits. A bad line makes two addresses that differ in one bit land on the same storage cell. Writing one of them then appears to change the other. The engine picks a test address and a walking one-hot mask. For each mask it forms a probe address as the test address XOR the mask. It skips any probe that falls outside the memory window. For each probe it keeps, it makes the test word hold the bitwise complement of the probe word. It then reads both words back. If the two readbacks are equal, the locations mirror each other, and the engine reports a fault.

A scan walks the mask from word-address bit 0 up to the top address bit, in two passes. The first pass uses the lowest word of the window as the test address, so a single one walks through zeros on the address lines. The second pass uses the last word of the window, so a single zero walks through ones. The window starts at `base_addr`, which may be unaligned, and holds 2^`win_log2` words.

The engine drives a single synchronous memory port. Read data returns on the cycle after a read request. A pulse on `start` runs one scan. At the end, `done` rises, with `fail` set if a fault was found, and both hold until the next start. The engine stops at the first mirrored pair. On a fault, the error outputs give the test address, the probe address and the mask.

Its control is one state machine with these states:
- **IDLE**: waits after reset.
- **SELECT**: checks whether the current probe lies inside the window. It goes to **RD_PROBE** if it does and to **ADVANCE** if it does not.
- **RD_PROBE** then **GET_PROBE**: read the probe word and capture it.
- **WR_TEST**: writes the complement of that word to the test address.
- **RD_RECHK** then **GET_RECHK**: read the probe word again and capture it.
- **RD_TEST** then **GET_TEST**: read the test word and capture it.
- **JUDGE**: compares the two captured readbacks. It goes to **DONE** on equality and to **ADVANCE** otherwise.
- **ADVANCE**: steps the mask. After the top bit it switches to the second pass, and after the second pass it goes to **DONE**.
- **DONE**: holds the result.

From **IDLE** or **DONE**, `start` leads to **SELECT**.

Top module: `addr_mirror_tester`

## Requirements
- R1: After reset, `done`, `fail` and `busy` are 0 and no memory request is made. A `start` pulse while not busy begins a scan, and on the next cycle `done` is 0 and `busy` is 1. A `start` while busy has no effect on the result.
- R2: In pass 0 the test address is `base_addr`. In pass 1 it is `base_addr + 2^win_log2 - 1`. In each pass the probe address is the test address XOR a one-hot mask whose set bit goes from bit 0 to bit AW-1 in ascending order.
- R3: A probe below `base_addr`, or at or above `base_addr + 2^win_log2`, is skipped without any memory access. No memory request ever addresses a word outside the window.
- R4: Each in-window probe costs exactly three reads and one write, in this order:
  - read the probe word;
  - write its bitwise complement to the test word;
  - read the probe word once;
  - read the test word once.
- R5: Writes go only to the current test address, which is one of the two window ends.
- R6: If the probe readback and the test readback of a probe are equal, the scan stops at once. `done` and `fail` are both 1, and no further probe is accessed.
- R7: If no probe mirrors, the scan covers both passes and ends with `done` = 1 and `fail` = 0.
- R8: On a fault, `err_test_addr` and `err_probe_addr` give the pair, and `err_mask` is one-hot with `err_probe_addr == err_test_addr ^ err_mask`.
- R9: Any base address is accepted, aligned or not, with 0 <= `win_log2` <= AW, provided `base_addr + 2^win_log2 <= 2^AW`. Inputs are held stable while busy.
- R10: `done` and `fail` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan when not busy |
| base_addr | input | AW | First word of the window |
| win_log2 | input | $clog2(AW+1) | Window size as log2 of word count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| fail | output | 1 | A mirrored pair was found |
| err_test_addr | output | AW | Test address of the fault |
| err_probe_addr | output | AW | Probe address of the fault |
| err_mask | output | AW | One-hot XOR mask of the fault |

## Verification
The bench sweeps a 64-word memory over window bases that are zero, aligned, unaligned and near the top, with every window size that fits. Each window is tried against a healthy memory and against each address bit stuck at 0 and stuck at 1. A healthy memory shows that the scan visits exactly the in-window probes, which the bench counts arithmetically through the read and write totals. A stuck line shows whether the fault lies where either window end can reach it across that bit, and the bench predicts the first faulting pass, pair and mask. Windows of one word, or windows whose flipped bit leads outside the range, show that out-of-range probes cause no access and that faults beyond the window go unreported.

// File: rtl/amt_pkg.sv
package amt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_RD_PROBE,
        ST_GET_PROBE,
        ST_WR_TEST,
        ST_RD_RECHK,
        ST_GET_RECHK,
        ST_RD_TEST,
        ST_GET_TEST,
        ST_JUDGE,
        ST_ADVANCE,
        ST_DONE
    } amt_state_e;

endpackage

// File: rtl/amt_probe_gen.sv
// Forms the test and probe addresses for the current pass and mask bit,
// and tells whether the probe lies inside the window.
module amt_probe_gen #(
    parameter int AW = 16,
    parameter int LW = $clog2(AW + 1),
    parameter int IW = $clog2(AW)
) (
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] win_log2,
    input  logic          pass_hi,
    input  logic [IW-1:0] bit_idx,
    output logic [AW-1:0] test_addr,
    output logic [AW-1:0] probe_addr,
    output logic [AW-1:0] mask,
    output logic          probe_ok
);
    localparam int EW = AW + 1;

    logic [EW-1:0] span;
    logic [EW-1:0] limit;
    logic [AW-1:0] last_word;

    // one-hot decode of the walking bit
    for (genvar j = 0; j < AW; j++) begin : g_mask
        assign mask[j] = (bit_idx == IW'(j));
    end

    always_comb begin
        span      = EW'(1) << win_log2;
        limit     = {1'b0, base_addr} + span;
        last_word = base_addr + span[AW-1:0] - AW'(1);
        test_addr = pass_hi ? last_word : base_addr;
        probe_addr = test_addr ^ mask;
        probe_ok  = ({1'b0, probe_addr} >= {1'b0, base_addr}) &&
                    ({1'b0, probe_addr} <  limit);
    end

endmodule

// File: rtl/amt_capture.sv
// Holds the three readbacks of one probe and produces the write value and
// the mirror verdict from registered copies only.
module amt_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_probe,
    input  logic          cap_rechk,
    input  logic          cap_test,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wr_val,
    output logic          mirrored
);
    logic [DW-1:0] probe_q;
    logic [DW-1:0] rechk_q;
    logic [DW-1:0] test_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_q <= '0;
            rechk_q <= '0;
            test_q  <= '0;
        end else begin
            if (cap_probe) probe_q <= rdata;
            if (cap_rechk) rechk_q <= rdata;
            if (cap_test)  test_q  <= rdata;
        end
    end

    assign wr_val   = ~probe_q;
    assign mirrored = (rechk_q == test_q);

endmodule

// File: rtl/addr_mirror_tester.sv
module addr_mirror_tester
    import amt_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] win_log2,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] err_test_addr,
    output logic [AW-1:0] err_probe_addr,
    output logic [AW-1:0] err_mask
);
    localparam int IW = $clog2(AW);
    localparam logic [IW-1:0] TOP_IDX = IW'(AW - 1);

    amt_state_e state_q, state_d;

    logic          pass_q;
    logic [IW-1:0] idx_q;
    logic          fail_q;
    logic [AW-1:0] err_test_q, err_probe_q, err_mask_q;

    logic [AW-1:0] test_addr, probe_addr, mask;
    logic          probe_ok;
    logic [DW-1:0] wr_val;
    logic          mirrored;
    logic          idle_like, accept, last_step;

    amt_probe_gen #(.AW(AW), .LW(LW), .IW(IW)) u_probe (
        .base_addr (base_addr),
        .win_log2  (win_log2),
        .pass_hi   (pass_q),
        .bit_idx   (idx_q),
        .test_addr (test_addr),
        .probe_addr(probe_addr),
        .mask      (mask),
        .probe_ok  (probe_ok)
    );

    amt_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_probe(state_q == ST_GET_PROBE),
        .cap_rechk(state_q == ST_GET_RECHK),
        .cap_test (state_q == ST_GET_TEST),
        .rdata    (mem_rdata),
        .wr_val   (wr_val),
        .mirrored (mirrored)
    );

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign accept    = idle_like && start;
    assign last_step = pass_q && (idx_q == TOP_IDX);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_SELECT;
            ST_DONE:      if (start) state_d = ST_SELECT;
            ST_SELECT:    state_d = probe_ok ? ST_RD_PROBE : ST_ADVANCE;
            ST_RD_PROBE:  state_d = ST_GET_PROBE;
            ST_GET_PROBE: state_d = ST_WR_TEST;
            ST_WR_TEST:   state_d = ST_RD_RECHK;
            ST_RD_RECHK:  state_d = ST_GET_RECHK;
            ST_GET_RECHK: state_d = ST_RD_TEST;
            ST_RD_TEST:   state_d = ST_GET_TEST;
            ST_GET_TEST:  state_d = ST_JUDGE;
            ST_JUDGE:     state_d = mirrored ? ST_DONE : ST_ADVANCE;
            ST_ADVANCE:   state_d = last_step ? ST_DONE : ST_SELECT;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // scan position and fault record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q      <= 1'b0;
            idx_q       <= '0;
            fail_q      <= 1'b0;
            err_test_q  <= '0;
            err_probe_q <= '0;
            err_mask_q  <= '0;
        end else if (accept) begin
            pass_q <= 1'b0;
            idx_q  <= '0;
            fail_q <= 1'b0;
        end else if (state_q == ST_ADVANCE && !last_step) begin
            if (idx_q == TOP_IDX) begin
                idx_q  <= '0;
                pass_q <= 1'b1;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end else if (state_q == ST_JUDGE && mirrored) begin
            fail_q      <= 1'b1;
            err_test_q  <= test_addr;
            err_probe_q <= probe_addr;
            err_mask_q  <= mask;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_RD_PROBE, ST_RD_RECHK: begin
                mem_req  = 1'b1;
                mem_addr = probe_addr;
            end
            ST_WR_TEST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = test_addr;
                mem_wdata = wr_val;
            end
            ST_RD_TEST: begin
                mem_req  = 1'b1;
                mem_addr = test_addr;
            end
            default: ;
        endcase
        busy           = !idle_like;
        done           = (state_q == ST_DONE);
        fail           = fail_q;
        err_test_addr  = err_test_q;
        err_probe_addr = err_probe_q;
        err_mask       = err_mask_q;
    end

endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
    parameter int AW = 16,
    parameter int LW = $clog2(AW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] base_addr,
    input logic [LW-1:0] win_log2,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] err_test_addr,
    input logic [AW-1:0] err_probe_addr,
    input logic [AW-1:0] err_mask
);
    logic [AW:0] lim;
    assign lim = {1'b0, base_addr} + ((AW + 1)'(1) << win_log2);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (({1'b0, mem_addr} >= {1'b0, base_addr}) &&
                     ({1'b0, mem_addr} < lim)));

    p_write_ends_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            ((mem_addr == base_addr) || ({1'b0, mem_addr} == lim - (AW + 1)'(1))));

    p_fail_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    p_err_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (($countones(err_mask) == 1) &&
                  (err_probe_addr == (err_test_addr ^ err_mask))));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail)));

endmodule

bind addr_mirror_tester amt_checker #(.AW(AW), .LW(LW)) u_amt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .base_addr     (base_addr),
    .win_log2      (win_log2),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .busy          (busy),
    .done          (done),
    .fail          (fail),
    .err_test_addr (err_test_addr),
    .err_probe_addr(err_probe_addr),
    .err_mask      (err_mask)
);

// File: tb/tb_addr_mirror_tester.sv
module tb_addr_mirror_tester;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int LW = $clog2(AW + 1);
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [LW-1:0] win_log2 = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, fail;
    logic [AW-1:0] err_test_addr, err_probe_addr, err_mask;

    int vectors = 0;
    int miscompares = 0;

    // fault model and memory
    logic          mem_init = 1'b0;
    logic          flt_on = 1'b0;
    logic          flt_hi = 1'b0;
    int            flt_bit = 0;
    logic [DW-1:0] mem [NW];
    int rd_cnt, wr_cnt, win_bad, wr_bad;
    int cur_base, cur_lim;

    always #10 clk = ~clk;

    addr_mirror_tester #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_addr(base_addr), .win_log2(win_log2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail),
        .err_test_addr(err_test_addr), .err_probe_addr(err_probe_addr),
        .err_mask(err_mask)
    );

    function automatic int phys(input int a);
        if (!flt_on) return a;
        if (flt_hi)  return a | (1 << flt_bit);
        return a & ~(1 << flt_bit);
    endfunction

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < NW; i++) mem[i] <= DW'(i * 29 + 7);
            rd_cnt = 0; wr_cnt = 0; win_bad = 0; wr_bad = 0;
        end else if (mem_req) begin
            int a;
            a = int'(mem_addr);
            if (a < cur_base || a >= cur_lim) win_bad++;
            if (mem_we) begin
                wr_cnt++;
                if (a != cur_base && a != cur_lim - 1) wr_bad++;
                mem[phys(a)] <= mem_wdata;
            end else begin
                rd_cnt++;
                mem_rdata <= mem[phys(a)];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int b, input int k, input bit fon, input int fb,
                            input bit fhi, input bit restart_mid);
        int lim, n, efail, eT, eP, eM, t, p, wait_n;
        lim = b + (1 << k);
        @(negedge clk);
        base_addr = AW'(b); win_log2 = LW'(k);
        flt_on = fon; flt_bit = fb; flt_hi = fhi;
        cur_base = b; cur_lim = lim;
        mem_init = 1'b1;
        @(negedge clk);
        mem_init = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && busy, "R1 start", {done, busy}, 1);
        // expected scan outcome (R2, R3, R4, R6, R9)
        n = 0; efail = 0; eT = 0; eP = 0; eM = 0;
        for (int ps = 0; ps < 2; ps++)
            for (int j = 0; j < AW; j++) begin
                t = (ps == 1) ? lim - 1 : b;
                p = t ^ (1 << j);
                if (efail == 0 && p >= b && p < lim) begin
                    n++;
                    if (fon && j == fb) begin
                        efail = 1; eT = t; eP = p; eM = 1 << j;
                    end
                end
            end
        wait_n = 0;
        while (!done && wait_n < 4000) begin
            if (restart_mid && wait_n == 4) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_n++;
        end
        chk(done, "R7 done reached", done, 1);
        chk(fail == efail[0], efail ? "R6 fault found" : "R7 clean pass", fail, efail);
        if (efail != 0) begin
            chk(int'(err_test_addr) == eT, "R8 err_test_addr", err_test_addr, eT);
            chk(int'(err_probe_addr) == eP, "R2 err_probe_addr", err_probe_addr, eP);
            chk(int'(err_mask) == eM, "R8 err_mask", err_mask, eM);
        end
        chk(rd_cnt == 3 * n, "R4 read count", rd_cnt, 3 * n);
        chk(wr_cnt == n, "R4 write count", wr_cnt, n);
        chk(win_bad == 0, "R3 out-of-window access", win_bad, 0);
        chk(wr_bad == 0, "R5 write off test address", wr_bad, 0);
        repeat (3) @(negedge clk);
        chk(done && fail == efail[0], "R10 result held", {done, fail}, {1'b1, efail[0]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int bases [6] = '{0, 8, 13, 32, 48, 61};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !fail && !busy && !mem_req, "R1 reset state",
            {done, fail, busy, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_req, "R1 idle after reset", {done, busy, mem_req}, 0);
        // R1 start ignored while busy
        run_case(13, 4, 1'b1, 2, 1'b0, 1'b1);
        run_case(0, 6, 1'b0, 0, 1'b0, 1'b1);
        // R9 sweep over bases and window sizes with every stuck line
        foreach (bases[bi]) begin
            for (int k = 0; k <= AW; k++) begin
                if (bases[bi] + (1 << k) <= NW) begin
                    run_case(bases[bi], k, 1'b0, 0, 1'b0, 1'b0);
                    for (int fb = 0; fb < AW; fb++) begin
                        run_case(bases[bi], k, 1'b1, fb, 1'b0, 1'b0);
                        run_case(bases[bi], k, 1'b1, fb, 1'b1, 1'b0);
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule